// File: doc/BRIEF.md
# Extended-Capability Parallel Port FIFO Core

This block is the host-side register and FIFO core of an extended-capability parallel port. A CPU reaches it through a byte-wide register bus with two banks. The low bank holds the data latch, a status view and the control register. The high bank holds the FIFO window, the two configuration registers and the extended control register (ECR). The ECR selects the operating mode, and changing the mode flushes the FIFO.

The byte FIFO has 16 entries and exposes full and empty flags. In test mode the CPU can both fill and drain the FIFO. That lets software find the depth and the service thresholds by probing. Configuration mode reports an 8-bit transfer word and shows that compression is absent. A service flag sets when the FIFO fill crosses a threshold that depends on the data direction. The flag is armed and cleared through the ECR service bit.

The peripheral-side handshake, address cycles, DMA transfers and the port pins are not part of this block. The direction bit and the mode are kept as internal state.

Top module: `ecp_fifo_core`

## Requirements
- R1: After reset the ECR reads 0x05 (mode SPP, service disabled, FIFO empty), the control register reads 0xC0, the data latch reads 0x00 and `svc_req` is low.
- R2: The ECR layout is: bits 7:5 mode (000 SPP, 001 PS2, 010 compatibility FIFO, 011 ECP, 110 test, 111 configuration), bit 4 error-interrupt disable, bit 3 DMA enable, bit 2 service, bit 1 full, bit 0 empty. Bits 1:0 are read-only. Writing 0x34 and reading the ECR back returns 0x35.
- R3: An ECR write that selects SPP or PS2, or that changes the mode, empties the FIFO. Rewriting the current FIFO-using mode keeps the FIFO contents.
- R4: Writes to high offset 0 push into the FIFO in modes 010, 011 and 110. Reads of high offset 0 pop in first-in first-out order, but only in test mode; in other modes the read shows the head without removing it.
- R5: The full flag (ECR bit 1) is set exactly when 16 bytes are held, and a push while full is dropped. The empty flag (ECR bit 0) stays low until the last byte is read. A read of an empty FIFO returns 0x00.
- R6: With the direction set to forward (control bit 5 = 0), a test-mode pop that leaves 8 entries free sets the service flag, provided the service flag is armed.
- R7: With the direction set to reverse (control bit 5 = 1), a push that brings the fill to 8 sets the service flag, provided the service flag is armed.
- R8: Writing ECR bit 2 = 0 arms the service flag. Writing ECR bit 2 = 1 disarms it and clears it. A mode change also clears it. ECR bit 2 reads 1 when the flag is disarmed or set. `svc_req` equals the flag. Once cleared, the flag does not set again until a new threshold crossing.
- R9: The direction (control bit 5) takes the written value only while the mode is PS2; in any other mode it keeps its value.
- R10: In configuration mode, high offset 0 reads 0x10 (ID field bits 6:4 = 001, an 8-bit word) and ignores writes. High offset 1 stores bits 6:0 and reads bit 7 (compression) as 0. Outside configuration mode, high offset 1 reads 0x00.
- R11: Low offset 0 is the data latch. Low offset 1 reads {`pin_status`, 3'b111}. Low offset 2 reads {2'b11, direction, control bits 4:0}. Offset 3 of either bank reads 0xFF.
- R12: If `bus_wr` and `bus_rd` are both high in one cycle, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_hi | input | 1 | Bank select: 1 = high bank |
| bus_addr | input | 2 | Register offset within the bank |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| pin_status | input | 5 | Peripheral status lines, shown in status bits 7:3 |
| svc_req | output | 1 | Service flag |

## Verification
The hardest situation to reach is a service-flag crossing that happens while the flag is armed, in the right direction, at the exact threshold fill. A crossing while the flag is already set, or one after it has been cleared and re-armed, is harder still. To get there, the stimulus first sets the direction in PS2 mode and then enters test mode with the service bit written to zero. It fills the FIFO to its full depth and drains it past both thresholds. Between drains it clears and re-arms the flag. This shows that the flag sets only at the crossing and never again below it.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  typedef enum logic [2:0] {
    MD_SPP   = 3'b000,
    MD_PS2   = 3'b001,
    MD_CFIFO = 3'b010,
    MD_ECP   = 3'b011,
    MD_TEST  = 3'b110,
    MD_CFG   = 3'b111
  } ecp_mode_e;

  // Modes in which the CPU may push into the FIFO window
  function automatic logic mode_has_fifo(logic [2:0] m);
    return (m == MD_CFIFO) || (m == MD_ECP) || (m == MD_TEST);
  endfunction

  // Modes whose selection always flushes the FIFO
  function automatic logic mode_flushes(logic [2:0] m);
    return (m == MD_SPP) || (m == MD_PS2);
  endfunction

  // Forward direction: free entries after a pop reach the threshold
  function automatic logic free_hit(int unsigned fill, int unsigned depth,
                                    int unsigned thr);
    return (depth - fill) == thr;
  endfunction

  // Reverse direction: filled entries after a push reach the threshold
  function automatic logic fill_hit(int unsigned fill, int unsigned thr);
    return fill == thr;
  endfunction

endpackage

// File: rtl/ecp_byte_fifo.sv
module ecp_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);

  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CMAX);
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> $stable(cnt));

  // R3
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/ecp_svc_ctl.sv
module ecp_svc_ctl
  import ecp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RTHR  = 8,
  parameter int WTHR  = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ecr_wr,
  input  logic          svc_bit_wr,
  input  logic          mode_chg,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic          dir_rev,
  input  logic [CW-1:0] cnt,
  output logic          svc_en,
  output logic          svc_flag
);

  logic [CW-1:0] cnt_up, cnt_dn;
  logic          fwd_evt, rev_evt, set_evt, clr_evt;

  assign cnt_up  = cnt + 1'b1;
  assign cnt_dn  = cnt - 1'b1;
  assign fwd_evt = pop_ok  & ~dir_rev & free_hit(32'(cnt_dn), DEPTH, WTHR);
  assign rev_evt = push_ok &  dir_rev & fill_hit(32'(cnt_up), RTHR);
  assign set_evt = svc_en & (fwd_evt | rev_evt);
  assign clr_evt = mode_chg | (ecr_wr & svc_bit_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_en   <= 1'b0;
      svc_flag <= 1'b0;
    end else begin
      if (ecr_wr) svc_en <= ~svc_bit_wr;
      if (clr_evt)      svc_flag <= 1'b0;
      else if (set_evt) svc_flag <= 1'b1;
    end
  end

  // R8
  svc_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_flag) |-> svc_en);

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !svc_flag);

  // R6 R7
  svc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_flag) |-> $past(push_ok || pop_ok));

endmodule

// File: rtl/ecp_fifo_core.sv
module ecp_fifo_core
  import ecp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RTHR  = DEPTH / 2,
  parameter int WTHR  = DEPTH / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_hi,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [4:0] pin_status,
  output logic       svc_req
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] CFGA_VAL = 8'h10;

  logic [2:0]    mode;
  logic          errdis, dmaen, dir_rev;
  logic [4:0]    ctrl_q;
  logic [7:0]    data_q;
  logic [6:0]    cfgb_q;

  logic          rd_ev, ecr_wr, ctl_wr, mode_chg, fifo_clr;
  logic          push_req, pop_req;
  logic          push_ok, pop_ok;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_full, fifo_empty;
  logic          svc_en, svc_flag;

  // Bus decode: a write wins over a read in the same cycle
  assign rd_ev    = bus_rd & ~bus_wr;
  assign ecr_wr   = bus_wr & bus_hi & (bus_addr == 2'd2);
  assign ctl_wr   = bus_wr & ~bus_hi & (bus_addr == 2'd2);
  assign mode_chg = ecr_wr & (bus_wdata[7:5] != mode);
  assign fifo_clr = ecr_wr & (mode_chg | mode_flushes(bus_wdata[7:5]));
  assign push_req = bus_wr & bus_hi & (bus_addr == 2'd0) & mode_has_fifo(mode);
  assign pop_req  = rd_ev & bus_hi & (bus_addr == 2'd0) & (mode == MD_TEST);
  assign push_ok  = push_req & ~fifo_full;
  assign pop_ok   = pop_req & ~fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MD_SPP;
      errdis  <= 1'b0;
      dmaen   <= 1'b0;
      dir_rev <= 1'b0;
      ctrl_q  <= '0;
      data_q  <= '0;
      cfgb_q  <= '0;
    end else if (bus_wr) begin
      if (ecr_wr) begin
        mode   <= bus_wdata[7:5];
        errdis <= bus_wdata[4];
        dmaen  <= bus_wdata[3];
      end
      if (ctl_wr) begin
        ctrl_q <= bus_wdata[4:0];
        if (mode == MD_PS2) dir_rev <= bus_wdata[5];
      end
      if (!bus_hi && bus_addr == 2'd0) data_q <= bus_wdata;
      if (bus_hi && bus_addr == 2'd1 && mode == MD_CFG) cfgb_q <= bus_wdata[6:0];
    end
  end

  ecp_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (bus_wdata),
    .head  (fifo_head),
    .cnt   (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  ecp_svc_ctl #(.DEPTH(DEPTH), .RTHR(RTHR), .WTHR(WTHR)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecr_wr     (ecr_wr),
    .svc_bit_wr (bus_wdata[2]),
    .mode_chg   (mode_chg),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .dir_rev    (dir_rev),
    .cnt        (fifo_cnt),
    .svc_en     (svc_en),
    .svc_flag   (svc_flag)
  );

  assign svc_req = svc_flag;

  always_comb begin
    bus_rdata = 8'hFF;
    if (bus_hi) begin
      case (bus_addr)
        2'd0: bus_rdata = (mode == MD_CFG) ? CFGA_VAL :
                          (fifo_empty ? 8'h00 : fifo_head);
        2'd1: bus_rdata = (mode == MD_CFG) ? {1'b0, cfgb_q} : 8'h00;
        2'd2: bus_rdata = {mode, errdis, dmaen, (~svc_en | svc_flag),
                           fifo_full, fifo_empty};
        default: bus_rdata = 8'hFF;
      endcase
    end else begin
      case (bus_addr)
        2'd0: bus_rdata = data_q;
        2'd1: bus_rdata = {pin_status, 3'b111};
        2'd2: bus_rdata = {2'b11, dir_rev, ctrl_q};
        default: bus_rdata = 8'hFF;
      endcase
    end
  end

  // R9
  dir_ps2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_rev) |-> $past(mode) == MD_PS2);

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  // R12
  wr_over_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |-> !pop_ok);

endmodule

// File: tb/ecp_fifo_core_bench.sv
module ecp_fifo_core_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_hi = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [4:0] pin_status = 5'h1B;
  logic       svc_req;

  always #4 clk = ~clk;

  ecp_fifo_core u_ecp_fifo_core (
    .clk(clk), .rst_n(rst_n), .bus_hi(bus_hi), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_status(pin_status), .svc_req(svc_req)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int       m_mode = 0;
  bit       m_errdis = 0, m_dma = 0, m_en = 0, m_flag = 0, m_dir = 0;
  bit [4:0] m_ctrl = 0;
  bit [7:0] m_data = 0;
  bit [6:0] m_cfgb = 0;
  byte unsigned q[$];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input bit hi, input int a);
    if (a == 3) return 8'hFF;
    if (hi) begin
      if (a == 0) return (m_mode == 7) ? 8'h10 : (q.size() == 0 ? 8'h00 : q[0]);
      if (a == 1) return (m_mode == 7) ? {1'b0, m_cfgb} : 8'h00;
      return {3'(m_mode), m_errdis, m_dma, (!m_en) || m_flag,
              q.size() == 16, q.size() == 0};
    end
    if (a == 0) return m_data;
    if (a == 1) return {pin_status, 3'b111};
    return {2'b11, m_dir, m_ctrl};
  endfunction

  task automatic m_write(input bit hi, input int a, input bit [7:0] d);
    int nm;
    if (!hi) begin
      if (a == 0) m_data = d;
      if (a == 2) begin m_ctrl = d[4:0]; if (m_mode == 1) m_dir = d[5]; end
    end else if (a == 0) begin
      if ((m_mode == 2 || m_mode == 3 || m_mode == 6) && q.size() < 16) begin
        q.push_back(d);
        if (m_dir && q.size() == 8 && m_en) m_flag = 1;
      end
    end else if (a == 1) begin
      if (m_mode == 7) m_cfgb = d[6:0];
    end else if (a == 2) begin
      nm = int'(d[7:5]);
      if (nm != m_mode || nm <= 1) q.delete();
      if (nm != m_mode) m_flag = 0;
      if (d[2]) begin m_en = 0; m_flag = 0; end else m_en = 1;
      m_mode = nm; m_errdis = d[4]; m_dma = d[3];
    end
  endtask

  task automatic m_rdside(input bit hi, input int a);
    if (hi && a == 0 && m_mode == 6 && q.size() > 0) begin
      void'(q.pop_front());
      if (!m_dir && (16 - q.size()) == 8 && m_en) m_flag = 1;
    end
  endtask

  task automatic op(input bit w, input bit r, input bit hi, input int a,
                    input bit [7:0] d, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_hi = hi; bus_addr = 2'(a); bus_wdata = d;
    #1;
    exp = m_read(hi, a);
    if (r && !w) chk(bus_rdata === exp, tag, bus_rdata, exp);
    chk(svc_req === m_flag, "R8 svc_req", {7'd0, svc_req}, {7'd0, m_flag});
    @(posedge clk);
    if (w) m_write(hi, a, d);
    else if (r) m_rdside(hi, a);
    #1 bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input bit hi, input int a, input bit [7:0] d, input string tag);
    op(1, 0, hi, a, d, tag);
  endtask

  task automatic rd(input bit hi, input int a, input string tag);
    op(0, 1, hi, a, 8'h00, tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    rd(1, 2, "R1 ecr reset");
    rd(0, 2, "R1 ctrl reset");
    rd(0, 0, "R1 data reset");

    // R2: readback of ECR with read-only flags
    wr(1, 2, 8'h34, "R2");
    rd(1, 2, "R2 ecr readback");
    wr(1, 2, 8'h37, "R2 ro bits");
    rd(1, 2, "R2 ro bits ignored");

    // R11: low bank, and R9 direction set in PS2
    wr(0, 0, 8'hA5, "R11");
    rd(0, 0, "R11 data latch");
    rd(0, 1, "R11 status");
    rd(0, 3, "R11 low offset 3");
    rd(1, 3, "R11 high offset 3");
    wr(0, 2, 8'h2F, "R9");
    rd(0, 2, "R9 dir set in PS2");
    wr(0, 2, 8'h00, "R9");
    rd(0, 2, "R9 dir clear in PS2");

    // R10: configuration mode
    wr(1, 2, 8'hE4, "R10");
    rd(1, 0, "R10 cfgA");
    wr(1, 0, 8'h55, "R10 cfgA write ignored");
    rd(1, 0, "R10 cfgA unchanged");
    wr(1, 1, 8'hFF, "R10");
    rd(1, 1, "R10 cfgB compress reads 0");
    wr(1, 2, 8'hC4, "R10");
    rd(1, 1, "R10 cfgB hidden");

    // R4 R5: test mode fill to full and drain
    for (int i = 0; i < 17; i++) wr(1, 0, 8'(i * 7 + 3), "R5");
    rd(1, 2, "R5 full flag");
    for (int i = 0; i < 16; i++) begin
      rd(1, 0, "R4 fifo order");
      if (i == 14) rd(1, 2, "R5 empty low before last");
    end
    rd(1, 2, "R5 empty after last");
    rd(1, 0, "R5 empty read zero");

    // R6: forward threshold while draining
    wr(1, 2, 8'hC0, "R6");
    for (int i = 0; i < 16; i++) wr(1, 0, 8'(8'hF0 + i), "R6");
    for (int i = 0; i < 10; i++) rd(1, 0, "R6 drain");
    rd(1, 2, "R6 svc bit set");
    // R8: clear by writing one, re-arm, no second set below threshold
    wr(1, 2, 8'hC4, "R8");
    wr(1, 2, 8'hC0, "R8");
    for (int i = 0; i < 6; i++) rd(1, 0, "R8 no reset below thr");
    rd(1, 2, "R8 svc bit armed clear");

    // R7: reverse threshold while filling
    wr(1, 2, 8'h24, "R7");
    wr(0, 2, 8'h20, "R7");
    wr(1, 2, 8'hC0, "R7");
    for (int i = 0; i < 10; i++) wr(1, 0, 8'hAA, "R7");
    rd(1, 2, "R7 svc set");
    // R3 R8: mode change flushes and clears the flag
    wr(1, 2, 8'h60, "R3");
    rd(1, 2, "R3 mode change flushes");

    // R9: dir frozen outside PS2
    wr(0, 2, 8'h01, "R9");
    rd(0, 2, "R9 dir kept in ECP");

    // R3 R4: same-mode rewrite keeps, non-test reads do not pop
    wr(1, 0, 8'h11, "R4");
    wr(1, 0, 8'h22, "R4");
    wr(1, 2, 8'h64, "R3");
    rd(1, 0, "R4 peek in ECP");
    rd(1, 0, "R4 peek again");
    rd(1, 2, "R3 kept after rewrite");
    wr(1, 2, 8'h44, "R3");
    rd(1, 2, "R3 flushed on change");
    wr(1, 0, 8'h33, "R4");
    wr(1, 2, 8'hC4, "R3");
    rd(1, 2, "R3 flushed to test");

    // R12: simultaneous write and read
    wr(1, 0, 8'h77, "R12");
    op(1, 1, 1, 0, 8'h88, "R12");
    rd(1, 0, "R12 first kept");
    rd(1, 0, "R12 write taken");
    wr(1, 2, 8'h04, "R3");
    rd(1, 2, "R3 spp flush");

    done = 1;
    summary();
    $finish;
  end

endmodule